// File: doc/BRIEF.md
# Target-Aware Address Pointer Unit

This block keeps the address pointer that the read and write paths of a small bus-configured device share. The pointer holds two things: a target, which is the register bank, the configuration memory or the user memory, and an 8-bit address within that target. The protocol controller drives it with three kinds of strobe. A command strobe carries a command byte. A data strobe carries the address byte that follows a memory-select command. An increment strobe is raised after each data byte moves. One cycle after each command or data strobe, the block returns an accept pulse or a reject pulse, which the controller turns into ACK or NACK on the bus.

A command byte in the range 00h to 45h points straight at that register in the bank. The command bytes 80h, 81h and 82h do not move the pointer. They only arm a memory target, and the address arrives in the next data byte. When the pointer advances, configuration space (the register bank and the configuration memory) stops at the last legal address, so further bytes overwrite that address. User space wraps from FFh back to 00h. The memory arrays and the bus handling are outside this block.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset the target output `tgt` is 0 and `addr` is 00h, and `ack` and `nack` are low. The target codes are 0 for the register bank, 1 for configuration memory and 2 for user memory. Code 3 never appears.
- R2: A command strobe whose code is 00h to 45h sets the target to 0 and the address to the code. `ack` pulses in the cycle after the strobe.
- R3: Command 80h arms configuration memory, and 81h or 82h arms user memory. Each pulses `ack`, and neither changes `tgt` or `addr`.
- R4: A data strobe that follows an armed configuration target loads target 1 and the data byte when the byte is 00h to 45h. A data strobe that follows an armed user target loads target 2 with any byte. Both pulse `ack`.
- R5: A rejected preset pulses `nack` and leaves `tgt` and `addr` unchanged. The rejected presets are a command of 46h to 7Fh or 83h to FFh, a configuration data byte above 45h, and a data strobe with no armed target. Every data strobe and every command strobe other than 80h, 81h and 82h clears the armed target.
- R6: An increment on target 0 or 1 adds one up to 45h. At 45h the address stays at 45h.
- R7: An increment on target 2 adds one, and FFh becomes 00h.
- R8: An increment in the same cycle as any command or data strobe has no effect, whether the preset is accepted or rejected.
- R9: When a command strobe and a data strobe arrive in the same cycle, the command is handled and the data strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| data_stb | input | 1 | Address data byte strobe |
| data_byte | input | 8 | Address data byte |
| inc | input | 1 | Advance the pointer after a data byte |
| tgt | output | 2 | Current target (0 bank, 1 config, 2 user) |
| addr | output | 8 | Current address |
| ack | output | 1 | Preset accepted, one cycle after the strobe |
| nack | output | 1 | Preset rejected, one cycle after the strobe |

## Verification
A wrong target or address shows on `tgt` and `addr` in the cycle after the strobe or increment that caused it, so the bench compares every output on every cycle against its own model. A lost or stale arming has no immediate effect on the outputs. It shows only at the next data strobe, as a reject where an accept was due or the reverse. The bench therefore mixes commands, data bytes and increments in random order, so that arming errors turn into visible mismatches. Saturation and wrap errors appear only at 45h and FFh, and directed runs walk the pointer across both of these addresses.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    TGT_REG = 2'd0,
    TGT_CFG = 2'd1,
    TGT_USR = 2'd2
  } tgt_e;

  // an address is legal for a target when it fits that target's space
  function automatic logic addr_legal(tgt_e t, logic [ADDR_W-1:0] a,
                                      logic [ADDR_W-1:0] last);
    return (t == TGT_USR) ? 1'b1 : (a <= last);
  endfunction

  // configuration space saturates at its last address, user space wraps
  function automatic logic [ADDR_W-1:0] addr_advance(tgt_e t, logic [ADDR_W-1:0] a,
                                                     logic [ADDR_W-1:0] last);
    if (t == TGT_USR) return a + 1'b1;
    return (a >= last) ? last : a + 1'b1;
  endfunction
endpackage

// File: rtl/ptr_decode.sv
module ptr_decode
  import addr_ptr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_LAST  = 8'h45,
  parameter logic [ADDR_W-1:0] CMD_CFG   = 8'h80,
  parameter logic [ADDR_W-1:0] CMD_USR_A = 8'h81,
  parameter logic [ADDR_W-1:0] CMD_USR_B = 8'h82
) (
  input  logic              cmd_stb,
  input  logic [ADDR_W-1:0] cmd_code,
  input  logic              data_stb,
  input  logic [ADDR_W-1:0] data_byte,
  input  logic              arm_vld,
  input  tgt_e              arm_tgt,
  output logic              load_en,
  output tgt_e              load_tgt,
  output logic [ADDR_W-1:0] load_addr,
  output logic              arm_set,
  output tgt_e              arm_set_tgt,
  output logic              arm_clr,
  output logic              accept,
  output logic              reject
);
  logic is_direct, is_cfg, is_usr;
  assign is_direct = (cmd_code <= CFG_LAST);
  assign is_cfg    = (cmd_code == CMD_CFG);
  assign is_usr    = (cmd_code == CMD_USR_A) || (cmd_code == CMD_USR_B);

  always_comb begin
    load_en     = 1'b0;
    load_tgt    = TGT_REG;
    load_addr   = '0;
    arm_set     = 1'b0;
    arm_set_tgt = TGT_CFG;
    arm_clr     = 1'b0;
    accept      = 1'b0;
    reject      = 1'b0;
    if (cmd_stb) begin
      if (is_direct) begin
        load_en   = 1'b1;
        load_tgt  = TGT_REG;
        load_addr = cmd_code;
        accept    = 1'b1;
        arm_clr   = 1'b1;
      end else if (is_cfg || is_usr) begin
        arm_set     = 1'b1;
        arm_set_tgt = is_cfg ? TGT_CFG : TGT_USR;
        accept      = 1'b1;
      end else begin
        reject  = 1'b1;
        arm_clr = 1'b1;
      end
    end else if (data_stb) begin
      arm_clr = 1'b1;
      if (arm_vld && addr_legal(arm_tgt, data_byte, CFG_LAST)) begin
        load_en   = 1'b1;
        load_tgt  = arm_tgt;
        load_addr = data_byte;
        accept    = 1'b1;
      end else begin
        reject = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptr_arm.sv
module ptr_arm
  import addr_ptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  tgt_e arm_set_tgt,
  input  logic arm_clr,
  output logic arm_vld,
  output tgt_e arm_tgt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_vld <= 1'b0;
      arm_tgt <= TGT_CFG;
    end else if (arm_set) begin
      arm_vld <= 1'b1;
      arm_tgt <= arm_set_tgt;
    end else if (arm_clr) begin
      arm_vld <= 1'b0;
    end
  end

  // R3: an armed target is always a memory, never the register bank
  a_r3_arm_is_memory: assert property (@(posedge clk) disable iff (!rst_n)
    arm_vld |-> (arm_tgt != TGT_REG));
endmodule

// File: rtl/ptr_step.sv
module ptr_step
  import addr_ptr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_LAST = 8'h45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  tgt_e              load_tgt,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              inc_en,
  output tgt_e              cur_tgt,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_tgt  <= TGT_REG;
      cur_addr <= '0;
    end else if (load_en) begin
      cur_tgt  <= load_tgt;
      cur_addr <= load_addr;
    end else if (inc_en) begin
      cur_addr <= addr_advance(cur_tgt, cur_addr, CFG_LAST);
    end
  end

  a_r1_tgt_code: assert property (@(posedge clk) disable iff (!rst_n)
    cur_tgt != 2'd3);
  a_r6_cfg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_tgt != TGT_USR) |-> (cur_addr <= CFG_LAST));
  a_r6_cfg_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !load_en && cur_tgt != TGT_USR && cur_addr == CFG_LAST)
      |=> (cur_addr == CFG_LAST));
  a_r7_usr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !load_en && cur_tgt == TGT_USR && cur_addr == ADDR_MAX)
      |=> (cur_addr == '0));
endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
  import addr_ptr_pkg::*;
#(
  parameter logic [7:0] CFG_LAST  = 8'h45,
  parameter logic [7:0] CMD_CFG   = 8'h80,
  parameter logic [7:0] CMD_USR_A = 8'h81,
  parameter logic [7:0] CMD_USR_B = 8'h82
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_stb,
  input  logic [7:0] cmd_code,
  input  logic       data_stb,
  input  logic [7:0] data_byte,
  input  logic       inc,
  output logic [1:0] tgt,
  output logic [7:0] addr,
  output logic       ack,
  output logic       nack
);
  logic              load_en, arm_set, arm_clr, accept, reject, arm_vld;
  tgt_e              load_tgt, arm_set_tgt, arm_tgt, cur_tgt;
  logic [ADDR_W-1:0] load_addr, cur_addr;
  logic              any_stb, inc_en;

  // R8: any preset strobe suppresses an increment in the same cycle
  assign any_stb = cmd_stb | data_stb;
  assign inc_en  = inc & ~any_stb;

  ptr_decode #(
    .CFG_LAST(CFG_LAST), .CMD_CFG(CMD_CFG),
    .CMD_USR_A(CMD_USR_A), .CMD_USR_B(CMD_USR_B)
  ) u_decode (
    .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .data_stb(data_stb), .data_byte(data_byte),
    .arm_vld(arm_vld), .arm_tgt(arm_tgt),
    .load_en(load_en), .load_tgt(load_tgt), .load_addr(load_addr),
    .arm_set(arm_set), .arm_set_tgt(arm_set_tgt), .arm_clr(arm_clr),
    .accept(accept), .reject(reject)
  );

  ptr_arm u_arm (
    .clk(clk), .rst_n(rst_n),
    .arm_set(arm_set), .arm_set_tgt(arm_set_tgt), .arm_clr(arm_clr),
    .arm_vld(arm_vld), .arm_tgt(arm_tgt)
  );

  ptr_step #(.CFG_LAST(CFG_LAST)) u_step (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .load_tgt(load_tgt), .load_addr(load_addr),
    .inc_en(inc_en),
    .cur_tgt(cur_tgt), .cur_addr(cur_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      nack <= 1'b0;
    end else begin
      ack  <= accept;
      nack <= reject;
    end
  end

  assign tgt  = cur_tgt;
  assign addr = cur_addr;

  a_r2_ack_nack_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && nack));
  a_r5_nack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> ($stable(tgt) && $stable(addr)));
  a_r8_no_response_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb |=> !(ack || nack));
endmodule

// File: tb/addr_ptr_unit_bench.sv
`timescale 1ns/1ps
module addr_ptr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_stb = 1'b0, data_stb = 1'b0, inc = 1'b0;
  logic [7:0] cmd_code = '0, data_byte = '0;
  logic [1:0] tgt;
  logic [7:0] addr;
  logic       ack, nack;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state
  logic [1:0] m_tgt = 2'd0;
  logic [7:0] m_addr = 8'h00;
  bit         m_armed = 1'b0;
  logic [1:0] m_arm_tgt = 2'd1;
  bit         m_ack = 1'b0, m_nack = 1'b0;

  always #4 clk = ~clk;

  addr_ptr_unit u_addr_ptr_unit (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .data_stb(data_stb), .data_byte(data_byte), .inc(inc),
    .tgt(tgt), .addr(addr), .ack(ack), .nack(nack)
  );

  function automatic logic [7:0] model_step(logic [1:0] t, logic [7:0] a);
    if (t == 2'd2) return (a == 8'hFF) ? 8'h00 : a + 8'd1;
    if (a == 8'h45) return 8'h45;
    return a + 8'd1;
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (tgt !== m_tgt || addr !== m_addr || ack !== m_ack || nack !== m_nack) begin
      fails++;
      $display("FAIL %s: got tgt=%0d addr=%02h ack=%0b nack=%0b, expected tgt=%0d addr=%02h ack=%0b nack=%0b",
               tag, tgt, addr, ack, nack, m_tgt, m_addr, m_ack, m_nack);
    end
  endtask

  // called at a falling edge: drive, update the model, check at the next falling edge
  task automatic apply(bit cs, logic [7:0] cc, bit ds, logic [7:0] db, bit in, string tag);
    cmd_stb = cs; cmd_code = cc; data_stb = ds; data_byte = db; inc = in;
    m_ack = 1'b0; m_nack = 1'b0;
    if (cs) begin
      if (cc <= 8'h45) begin
        m_tgt = 2'd0; m_addr = cc; m_ack = 1'b1; m_armed = 1'b0;
      end else if (cc == 8'h80) begin
        m_armed = 1'b1; m_arm_tgt = 2'd1; m_ack = 1'b1;
      end else if (cc == 8'h81 || cc == 8'h82) begin
        m_armed = 1'b1; m_arm_tgt = 2'd2; m_ack = 1'b1;
      end else begin
        m_nack = 1'b1; m_armed = 1'b0;
      end
    end else if (ds) begin
      if (m_armed && (m_arm_tgt == 2'd2 || db <= 8'h45)) begin
        m_tgt = m_arm_tgt; m_addr = db; m_ack = 1'b1;
      end else begin
        m_nack = 1'b1;
      end
      m_armed = 1'b0;
    end else if (in) begin
      m_addr = model_step(m_tgt, m_addr);
    end
    @(negedge clk);
    cmd_stb = 1'b0; data_stb = 1'b0; inc = 1'b0;
    compare(tag);
  endtask

  task automatic idle(string tag);
    apply(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");

    // R2: direct register presets at both ends of the bank
    apply(1'b1, 8'h00, 1'b0, 8'h00, 1'b0, "R2 direct 00h");
    apply(1'b1, 8'h45, 1'b0, 8'h00, 1'b0, "R2 direct 45h");
    // R6: saturation on the register bank
    apply(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R6 bank inc at 45h");
    apply(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R6 bank inc at 45h again");
    // R5: illegal commands
    apply(1'b1, 8'h46, 1'b0, 8'h00, 1'b0, "R5 cmd 46h rejected");
    apply(1'b1, 8'h83, 1'b0, 8'h00, 1'b0, "R5 cmd 83h rejected");
    apply(1'b0, 8'h00, 1'b1, 8'h10, 1'b0, "R5 data without arm");
    // R3/R4: configuration memory arm then legal and illegal data
    apply(1'b1, 8'h80, 1'b0, 8'h00, 1'b0, "R3 arm config");
    apply(1'b0, 8'h00, 1'b1, 8'h43, 1'b0, "R4 config data 43h");
    apply(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R6 config inc 43h");
    apply(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R6 config inc 44h");
    apply(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R6 config stays 45h");
    apply(1'b1, 8'h80, 1'b0, 8'h00, 1'b0, "R3 arm config again");
    apply(1'b0, 8'h00, 1'b1, 8'h46, 1'b0, "R5 config data 46h rejected");
    apply(1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R5 arm consumed by rejected data");
    // R3/R4/R7: user memory wrap
    apply(1'b1, 8'h82, 1'b0, 8'h00, 1'b0, "R3 arm user 82h");
    apply(1'b0, 8'h00, 1'b1, 8'hFE, 1'b0, "R4 user data FEh");
    apply(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R7 user inc FEh");
    apply(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R7 user wrap FFh");
    // R8: preset beats increment, accepted and rejected
    apply(1'b1, 8'h20, 1'b0, 8'h00, 1'b1, "R8 accepted preset with inc");
    apply(1'b1, 8'h90, 1'b0, 8'h00, 1'b1, "R8 rejected preset with inc");
    apply(1'b1, 8'h81, 1'b0, 8'h00, 1'b1, "R8 arm with inc");
    // R9: command and data together
    apply(1'b1, 8'h81, 1'b1, 8'h77, 1'b0, "R9 cmd wins over data");
    apply(1'b0, 8'h00, 1'b1, 8'hC0, 1'b0, "R9 arm kept, data loads");
    // R3: arming leaves pointer unchanged for an idle cycle
    apply(1'b1, 8'h80, 1'b0, 8'h00, 1'b0, "R3 arm holds pointer");
    idle("R3 idle while armed");

    for (int i = 0; i < 4000; i++) begin
      int kind;
      logic [7:0] c, d;
      kind = $urandom_range(0, 9);
      d = 8'($urandom);
      case ($urandom_range(0, 3))
        0: c = 8'($urandom_range(0, 8'h45));
        1: c = 8'h80;
        2: c = 8'($urandom_range(8'h81, 8'h82));
        default: c = 8'($urandom);
      endcase
      if ($urandom_range(0, 1) == 0 && d > 8'h40) d = 8'($urandom_range(8'h3C, 8'h48));
      if (kind < 2)       apply(1'b1, c, $urandom_range(0, 1) == 1, d, $urandom_range(0, 1) == 1, "R2 R3 R5 R9 random cmd");
      else if (kind < 4)  apply(1'b0, c, 1'b1, d, $urandom_range(0, 1) == 1, "R4 R5 R8 random data");
      else if (kind < 9)  apply(1'b0, c, 1'b0, d, 1'b1, "R6 R7 random inc");
      else                idle("R1 random idle");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule